// File: doc/BRIEF.md
# Low-Power Halt Sequencer

This block decides when a microcontroller may drop into its deepest sleep state and brings it back out. Software writes a control word in which one bit asks for sleep and a second bit chooses how the wake-up condition is judged. The block then gates the main oscillator off and sends a one-cycle clear to the timing-generator prescaler and divider. It watches a shared external pin for the wake-up condition, and on wake-up it re-enables the oscillator and waits a fixed warm-up interval before it declares the core ready again.

The block runs on a slow clock that is always on, so it keeps watching the pin and counting while the main clock is gated off. The wake pin passes through a two-stage synchronizer. The same pin also acts as an external interrupt source that fires on a falling edge. Any change of the pin between entry into sleep and the end of warm-up also leaves the interrupt latch set, so software should clear stale latches before it enables interrupts again.

Top module: `stop_mode_ctrl`

## Requirements
- R1: After reset the state code is 0, `osc_en`, `ready` are 1, and `tg_clear`, `stop_flag`, `int_latch` are 0.
- R2: A write in IDLE with `wr_data[7]`=1 moves to the halted state (code 1) on that clock edge, unless R5 applies. In the halted state `osc_en`=0, `ready`=0 and `stop_flag`=1. A write with bit 7 clear changes nothing.
- R3: `tg_clear` is high for exactly the first cycle of the halted state, and at no other time.
- R4: `wr_data[5]`=1 selects level wake-up. A high pin ends the halted state on the third clock edge after the pin rises, which is two synchronizer stages plus the state register.
- R5: With level wake-up selected, a sleep request made while the synchronized pin is already high goes straight to warm-up (code 2). `tg_clear` stays 0 and the oscillator is never gated.
- R6: `wr_data[5]`=0 selects edge wake-up. Only a rising pin edge ends the halted state, and a pin held high or low keeps it halted.
- R7: Warm-up lasts exactly 2^`WARM_BITS` cycles. During warm-up `osc_en`=1 and `ready`=0. Afterwards the state is IDLE with `ready`=1 and `stop_flag`=0.
- R8: Writes made while the state is halted or warming up are ignored. They do not re-pulse `tg_clear`, change the state or lengthen warm-up.
- R9: Any change of the synchronized pin while the state is halted or warming up sets `int_latch`.
- R10: In IDLE a falling pin edge sets `int_latch`; a rising edge does not.
- R11: `int_ack` clears `int_latch` one cycle later. When a set event and `int_ack` fall in the same cycle, the latch ends up set.
- R12: The state codes are 0 IDLE, 1 halted, 2 warm-up. `stop_flag` is 1 exactly when the code is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running low-speed clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | DATA_W | Control word: bit 7 sleep request, bit 5 wake-up select (1 level, 0 edge) |
| stop_pin | input | 1 | Asynchronous shared wake/interrupt pin |
| int_ack | input | 1 | Clears the interrupt latch |
| osc_en | output | 1 | Main oscillator enable |
| tg_clear | output | 1 | One-cycle clear to prescaler and divider |
| ready | output | 1 | Core clock is usable |
| stop_flag | output | 1 | Sleep request bit as read back; clears itself after warm-up |
| status | output | 2 | State code (see R12) |
| int_latch | output | 1 | External interrupt latch |

## Verification
Two things can land on the same clock edge. A pin rising edge can end the halted state and, on that same edge, set the interrupt latch. A falling pin edge can set the latch in the same cycle that `int_ack` clears it. The bench runs every combination of wake-up mode and initial pin level and checks both the state code and the latch on the edge where the wake-up happens. It also sets `int_ack` exactly on the third edge after a falling pin, where the latch set arrives, and expects the latch to stay set.

// File: rtl/stopctl_pkg.sv
// Shared definitions for the halt sequencer: state codes and control-word
// bit positions. Assumes the control word is at least 8 bits wide.
package stopctl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HALT = 2'd1,
        ST_WARM = 2'd2
    } halt_state_e;

    localparam int REQ_BIT = 7;   // sleep request
    localparam int SEL_BIT = 5;   // 1: level wake-up, 0: edge wake-up
endpackage

// File: rtl/stopctl_pin_sync.sv
// Two-flop synchronizer for the wake pin, with edge detection.
// Assumes clk is the always-on slow clock; reset clears all stages to 0.
module stopctl_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_lvl,
    output logic pin_rise,
    output logic pin_fall,
    output logic pin_chg
);
    logic meta_q, sync_q, prev_q;

    // Shift the pin through two stages and keep one earlier sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin_raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Decode level and edges from the synchronized stage.
    always_comb begin
        pin_lvl  = sync_q;
        pin_rise = sync_q & ~prev_q;
        pin_fall = ~sync_q & prev_q;
        pin_chg  = sync_q ^ prev_q;
    end
endmodule

// File: rtl/stopctl_warm_timer.sv
// Warm-up interval counter: while run is high it counts up from zero, and
// done is high in the final cycle of 2**BITS. Assumes run stays high until
// done has been seen; the count returns to zero whenever run is low.
module stopctl_warm_timer #(
    parameter int BITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam logic [BITS-1:0] LAST = {BITS{1'b1}};

    logic [BITS-1:0] cnt_q;

    // Count during warm-up, hold zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    // Flag the last cycle of the interval.
    always_comb done = run && (cnt_q == LAST);

    // R7: the count never runs past the last value while running.
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/stop_mode_ctrl.sv
// Halt sequencer top. It accepts a sleep request from a control-word write,
// gates the oscillator, clears the timing generator, watches the shared pin
// for a level or edge wake-up, runs warm-up and keeps the interrupt latch.
// Assumes clk keeps running while the main oscillator is off.
module stop_mode_ctrl #(
    parameter int DATA_W    = 8,
    parameter int WARM_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              stop_pin,
    input  logic              int_ack,
    output logic              osc_en,
    output logic              tg_clear,
    output logic              ready,
    output logic              stop_flag,
    output logic [1:0]        status,
    output logic              int_latch
);
    import stopctl_pkg::*;

    halt_state_e state_q, state_d;
    logic        lvl_mode_q;
    logic        clr_q;
    logic        latch_q;
    logic        pin_lvl, pin_rise, pin_fall, pin_chg;
    logic        warm_done;
    logic        req, req_lvl, wake, latch_set;

    stopctl_pin_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (stop_pin),
        .pin_lvl  (pin_lvl),
        .pin_rise (pin_rise),
        .pin_fall (pin_fall),
        .pin_chg  (pin_chg)
    );

    stopctl_warm_timer #(.BITS(WARM_BITS)) u_warm (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_WARM),
        .done  (warm_done)
    );

    // Decode the request and the wake-up condition.
    always_comb begin
        req       = wr_en && wr_data[REQ_BIT];
        req_lvl   = wr_data[SEL_BIT];
        wake      = lvl_mode_q ? pin_lvl : pin_rise;
        latch_set = ((state_q != ST_IDLE) && pin_chg) || pin_fall;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req) state_d = (req_lvl && pin_lvl) ? ST_WARM : ST_HALT;
            ST_HALT: if (wake) state_d = ST_WARM;
            ST_WARM: if (warm_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State, wake-up mode capture and the entry clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            lvl_mode_q <= 1'b0;
            clr_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            clr_q   <= (state_q == ST_IDLE) && (state_d == ST_HALT);
            if (state_q == ST_IDLE && req) lvl_mode_q <= req_lvl;
        end
    end

    // Interrupt latch: a set event wins over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)         latch_q <= 1'b0;
        else if (latch_set) latch_q <= 1'b1;
        else if (int_ack)   latch_q <= 1'b0;
    end

    // Drive the outputs from state.
    always_comb begin
        osc_en    = (state_q != ST_HALT);
        ready     = (state_q == ST_IDLE);
        stop_flag = (state_q != ST_IDLE);
        status    = state_q;
        tg_clear  = clr_q;
        int_latch = latch_q;
    end

    // R3: the clear pulse appears only on the first halted cycle.
    a_r3_clear_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        tg_clear |-> (status == 2'd1 && $past(status) == 2'd0));
    // R5: level mode with the pin already high skips the halted state.
    a_r5_direct_warm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req && req_lvl && pin_lvl) |=> (status == 2'd2 && osc_en));
    // R6: edge mode stays halted without a rising edge.
    a_r6_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !lvl_mode_q && !pin_rise) |=> (status == 2'd1));
    // R7: warm-up is not cut short.
    a_r7_warm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WARM && !warm_done) |=> (status == 2'd2 && !ready));
    // R8: writes while busy never pulse the clear.
    a_r8_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && wr_en) |=> !tg_clear);
    // R9: pin activity while asleep or warming sets the latch.
    a_r9_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && pin_chg) |=> int_latch);
    // R11: set beats acknowledge in the same cycle.
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_fall && int_ack) |=> int_latch);
endmodule

// File: tb/stop_mode_ctrl_test.sv
module stop_mode_ctrl_test;
    localparam int WB       = 3;
    localparam int WARM_LEN = 1 << WB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       stop_pin = 1'b0;
    logic       int_ack = 1'b0;
    logic       osc_en, tg_clear, ready, stop_flag, int_latch;
    logic [1:0] status;

    int checks = 0;
    int fails  = 0;

    stop_mode_ctrl #(.DATA_W(8), .WARM_BITS(WB)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .stop_pin(stop_pin), .int_ack(int_ack), .osc_en(osc_en),
        .tg_clear(tg_clear), .ready(ready), .stop_flag(stop_flag),
        .status(status), .int_latch(int_latch)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic ack();
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    // Counts warm-up cycles; writes a sleep request on the second one (R8).
    task automatic measure_warm(output int n);
        int guard = 0;
        n = 0;
        while (status != 2'd0 && guard < 200) begin
            if (status == 2'd2) begin
                n++;
                chk("R7 osc_en in warm-up", osc_en, 1);
                chk("R7 ready in warm-up", ready, 0);
            end
            if (n == 2) begin wr_en = 1'b1; wr_data = 8'hA0; end
            else        begin wr_en = 1'b0; wr_data = 8'h00; end
            guard++;
            @(negedge clk);
        end
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic run_case(input bit lvl, input bit p0);
        int n;
        stop_pin = p0;
        cyc(6);
        ack();
        chk("R11 latch cleared by ack", int_latch, 0);
        write(8'h80 | (lvl ? 8'h20 : 8'h00));
        if (lvl && p0) begin
            chk("R5 direct warm-up state", status, 2);
            chk("R5 no clear pulse", tg_clear, 0);
            chk("R5 oscillator stays on", osc_en, 1);
            chk("R12 stop_flag in warm-up", stop_flag, 1);
        end else begin
            chk("R2 halted state", status, 1);
            chk("R2 oscillator off", osc_en, 0);
            chk("R2 ready low", ready, 0);
            chk("R12 stop_flag halted", stop_flag, 1);
            chk("R3 clear on entry", tg_clear, 1);
            cyc(1);
            chk("R3 clear one cycle", tg_clear, 0);
            write(8'h80);
            chk("R8 write while halted state", status, 1);
            chk("R8 write while halted no clear", tg_clear, 0);
            cyc(5);
            chk("R6 steady pin keeps halted", status, 1);
            if (p0) begin
                stop_pin = 1'b0;
                cyc(5);
                chk("R6 falling edge no wake", status, 1);
                chk("R9 fall during halt sets latch", int_latch, 1);
            end
            stop_pin = 1'b1;
            cyc(2);
            chk("R4 still halted before sync", status, 1);
            cyc(1);
            chk("R4 wake on third edge", status, 2);
            chk("R9 wake edge sets latch", int_latch, 1);
        end
        measure_warm(n);
        chk("R7 warm-up length", n, WARM_LEN);
        chk("R7 idle after warm-up", status, 0);
        chk("R7 ready after warm-up", ready, 1);
        chk("R7 stop_flag cleared", stop_flag, 0);
        chk("R8 no re-entry from busy write", tg_clear, 0);
        chk("R9 latch after sequence", int_latch, (lvl && p0) ? 0 : 1);
        stop_pin = 1'b0;
        cyc(5);
        ack();
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 status", status, 0);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 ready", ready, 1);
        chk("R1 tg_clear", tg_clear, 0);
        chk("R1 stop_flag", stop_flag, 0);
        chk("R1 int_latch", int_latch, 0);

        write(8'h20);
        chk("R2 bit 7 clear ignored", status, 0);
        chk("R2 bit 7 clear no pulse", tg_clear, 0);

        for (int m = 0; m < 2; m++)
            for (int p = 0; p < 2; p++)
                run_case(m[0], p[0]);

        // R10: edges in IDLE
        stop_pin = 1'b1;
        cyc(5);
        chk("R10 rising edge in IDLE", int_latch, 0);
        stop_pin = 1'b0;
        cyc(5);
        chk("R10 falling edge in IDLE", int_latch, 1);
        ack();
        chk("R11 ack clears", int_latch, 0);

        // R11: acknowledge coincides with set event
        stop_pin = 1'b1;
        cyc(5);
        stop_pin = 1'b0;
        cyc(2);
        int_ack = 1'b1;
        cyc(1);
        int_ack = 1'b0;
        chk("R11 set wins over ack", int_latch, 1);
        ack();
        chk("R11 ack after collision", int_latch, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule